// File: doc/BRIEF.md
# Power-On and Warm Reset Sequencer

This block stands between an external active-low reset pin, a supply-good indication, and the controller of a flash-style memory with its programmable logic. It tells a long reset applied after the supply has come up apart from a short reset applied once the device is running. The long (power-on) reset is followed by a configuration-load phase. Both kinds of reset end with one shared, fixed operational hold-off before memory accesses are allowed.

The block also protects the memory. A qualified warm reset that arrives while a program or erase cycle is running raises a single-cycle abort request. Access stays closed until the memory reports that it is idle again. Write starts are blocked outside the ready phase and whenever the low-voltage lockout input is high.

All durations are parameters counted in clock cycles. The reset pin passes through a synchronizer of `SYNC_STAGES` flops. The `supply_good` input is an asynchronous active-low clear for the whole sequencer.

All pins are plain level or strobe controls. No data moves through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pwr_rst_seq`

## Requirements
- R1: While `supply_good` is high and no qualified reset has been seen since it rose, `cfg_load`, `cfg_done`, `pld_valid`, `access_rdy` and `flash_abort` are 0 and `wr_inhibit` is 1.
- R2: A power-on reset is qualified on the `POR_MIN_CYC`-th consecutive clock edge at which the synchronised pin reads low. A shorter low pulse leaves every output unchanged and triggers no configuration load.
- R3: `cfg_load` is 1 for exactly the one cycle after a power-on reset qualifies. `cfg_done` rises `CFG_LOAD_CYC` cycles after `cfg_load` rose, and it stays 1 until `supply_good` falls.
- R4: `pld_valid` is 0 until the configuration load completes. After that it is 1, including throughout any warm reset.
- R5: Reset release is measured from the first edge that samples the pin high, and this applies after both kinds of reset. Once configuration is done, `access_rdy` rises `SYNC_STAGES + OPR_DELAY_CYC + 1` edges after that first high sample, provided `flash_busy` is 0. `access_rdy` is never 1 while `cfg_done` is 0.
- R6: Once configured, a reset is qualified as warm on the `WARM_MIN_CYC`-th consecutive low synchronised sample, and `access_rdy` drops in the cycle after that edge. A shorter low pulse leaves `access_rdy` at 1.
- R7: When a warm reset qualifies while `flash_busy` is 1, `flash_abort` is 1 for exactly the following cycle. No abort is raised when `flash_busy` is 0.
- R8: At the end of the hold-off, `access_rdy` stays 0 for as long as `flash_busy` is 1. It rises on the first edge that samples `flash_busy` at 0.
- R9: `wr_inhibit` is 1 whenever `access_rdy` is 0 or `lockout` is 1. It follows `lockout` combinationally. `lockout` has no effect on `access_rdy`.
- R10: A low level on `supply_good` at once clears `cfg_done`, `pld_valid`, `access_rdy`, `cfg_load` and `flash_abort`. A new power-on reset is then needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| supply_good | input | 1 | Supply steady; low clears the sequencer asynchronously |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| lockout | input | 1 | Supply below write lockout threshold |
| flash_busy | input | 1 | Memory program or erase cycle in progress |
| cfg_load | output | 1 | One-cycle strobe starting the configuration load |
| cfg_done | output | 1 | Configuration load completed |
| pld_valid | output | 1 | Programmable logic outputs valid |
| access_rdy | output | 1 | Memory accesses allowed |
| wr_inhibit | output | 1 | Memory write starts blocked |
| flash_abort | output | 1 | One-cycle request to abort program/erase and return to read |

## Verification
Latencies are counted from the first clock edge that samples a new pin level:
- `cfg_load` appears after `SYNC_STAGES + POR_MIN_CYC` edges.
- `cfg_done` appears `CFG_LOAD_CYC` edges later still.
- A warm reset drops `access_rdy` and raises any abort after `SYNC_STAGES + WARM_MIN_CYC` edges.
- `access_rdy` returns `SYNC_STAGES + OPR_DELAY_CYC + 1` edges after release.
- `wr_inhibit` answers `lockout` within the same cycle.

A behavioural model in the bench advances on the same edges, using a queue for the synchronizer and countdowns for the phases. Every output is compared against it at each falling clock edge. Directed checks sample two time units after a rising edge, one cycle before and one cycle after each due edge, so a single-cycle shift in any latency is reported.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  // Sequencer phases
  typedef enum logic [2:0] {
    PH_OFF       = 3'd0,  // supply up, waiting for a reset pulse
    PH_POR_HOLD  = 3'd1,  // measuring a power-on pulse
    PH_CFG_LOAD  = 3'd2,  // configuration bits being loaded
    PH_OPR_WAIT  = 3'd3,  // post-release operational hold-off
    PH_READY     = 3'd4,  // memory accesses allowed
    PH_WARM_HOLD = 3'd5   // configured, reset still held
  } rsq_phase_e;

  function automatic int unsigned rsq_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rsq_sync.sv
// Multi-flop synchronizer for one asynchronous level; STAGES = 0 bypasses it.
module rsq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic din,
  output logic dout
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
          sr <= {STAGES{RST_VAL}};
        end else begin
          sr[0] <= din;
          for (int i = 1; i < int'(STAGES); i++) begin
            sr[i] <= sr[i-1];
          end
        end
      end
      assign dout = sr[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/rsq_width_meter.sv
// Counts consecutive held samples and flags when each minimum width is reached.
module rsq_width_meter #(
  parameter int unsigned POR_MIN  = 16,
  parameter int unsigned WARM_MIN = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic held,
  output logic por_ok,
  output logic warm_ok
);

  localparam int unsigned MAXW = rsq_pkg::rsq_max(POR_MIN, WARM_MIN);
  localparam int unsigned CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] SAT      = CW'(MAXW);
  localparam logic [CW-1:0] POR_LIM  = CW'(POR_MIN - 1);
  localparam logic [CW-1:0] WARM_LIM = CW'(WARM_MIN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt <= '0;
    end else if (!held) begin
      cnt <= '0;
    end else if (cnt != SAT) begin
      cnt <= cnt + 1'b1;
    end
  end

  // This edge is the N-th consecutive held sample when N-1 were already counted.
  assign por_ok  = held && (cnt >= POR_LIM);
  assign warm_ok = held && (cnt >= WARM_LIM);

endmodule

// File: rtl/rsq_phase_timer.sv
// Counts cycles spent in one phase; done from the LIMIT-th cycle on.
module rsq_phase_timer #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic run,
  output logic done
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = run && (cnt == LAST);

endmodule

// File: rtl/rsq_fsm.sv
// Phase controller: power-on qualification, configuration, hold-off, warm reset.
module rsq_fsm
  import rsq_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       held,
  input  logic       por_ok,
  input  logic       warm_ok,
  input  logic       cfg_tmr_done,
  input  logic       opr_tmr_done,
  input  logic       flash_busy,
  output rsq_phase_e phase,
  output logic       cfg_run,
  output logic       opr_run,
  output logic       cfg_load,
  output logic       cfg_done,
  output logic       flash_abort
);

  rsq_phase_e nxt;
  logic       ld_set;
  logic       abort_set;
  logic       done_set;

  always_comb begin
    nxt       = phase;
    ld_set    = 1'b0;
    abort_set = 1'b0;
    done_set  = 1'b0;
    unique case (phase)
      PH_OFF: begin
        if (por_ok) begin
          nxt    = PH_CFG_LOAD;
          ld_set = 1'b1;
        end else if (held) begin
          nxt = PH_POR_HOLD;
        end
      end
      PH_POR_HOLD: begin
        if (por_ok) begin
          nxt    = PH_CFG_LOAD;
          ld_set = 1'b1;
        end else if (!held) begin
          nxt = PH_OFF;  // pulse too short: forget it
        end
      end
      PH_CFG_LOAD: begin
        if (cfg_tmr_done) begin
          done_set = 1'b1;
          nxt      = held ? PH_WARM_HOLD : PH_OPR_WAIT;
        end
      end
      PH_WARM_HOLD: begin
        if (!held) nxt = PH_OPR_WAIT;
      end
      PH_OPR_WAIT: begin
        if (warm_ok) begin
          nxt       = PH_WARM_HOLD;
          abort_set = flash_busy;
        end else if (opr_tmr_done && !flash_busy) begin
          nxt = PH_READY;
        end
      end
      PH_READY: begin
        if (warm_ok) begin
          nxt       = PH_WARM_HOLD;
          abort_set = flash_busy;
        end
      end
      default: nxt = PH_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      phase       <= PH_OFF;
      cfg_load    <= 1'b0;
      cfg_done    <= 1'b0;
      flash_abort <= 1'b0;
    end else begin
      phase       <= nxt;
      cfg_load    <= ld_set;
      flash_abort <= abort_set;
      if (done_set) cfg_done <= 1'b1;
    end
  end

  assign cfg_run = (phase == PH_CFG_LOAD);
  assign opr_run = (phase == PH_OPR_WAIT);

endmodule

// File: rtl/pwr_rst_seq.sv
// Power-on / warm reset sequencer top.
module pwr_rst_seq
  import rsq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned POR_MIN_CYC   = 16,
  parameter int unsigned WARM_MIN_CYC  = 4,
  parameter int unsigned CFG_LOAD_CYC  = 8,
  parameter int unsigned OPR_DELAY_CYC = 12
) (
  input  logic clk,
  input  logic supply_good,
  input  logic rst_pin_n,
  input  logic lockout,
  input  logic flash_busy,
  output logic cfg_load,
  output logic cfg_done,
  output logic pld_valid,
  output logic access_rdy,
  output logic wr_inhibit,
  output logic flash_abort
);

  logic       pin_s;
  logic       held;
  logic       por_ok;
  logic       warm_ok;
  logic       cfg_run;
  logic       opr_run;
  logic       cfg_tmr_done;
  logic       opr_tmr_done;
  rsq_phase_e phase;

  rsq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .arst_n(supply_good), .din(rst_pin_n), .dout(pin_s)
  );

  assign held = ~pin_s;

  rsq_width_meter #(.POR_MIN(POR_MIN_CYC), .WARM_MIN(WARM_MIN_CYC)) u_meter (
    .clk(clk), .arst_n(supply_good), .held(held),
    .por_ok(por_ok), .warm_ok(warm_ok)
  );

  rsq_phase_timer #(.LIMIT(CFG_LOAD_CYC)) u_cfg_tmr (
    .clk(clk), .arst_n(supply_good), .run(cfg_run), .done(cfg_tmr_done)
  );

  rsq_phase_timer #(.LIMIT(OPR_DELAY_CYC)) u_opr_tmr (
    .clk(clk), .arst_n(supply_good), .run(opr_run), .done(opr_tmr_done)
  );

  rsq_fsm u_fsm (
    .clk(clk), .arst_n(supply_good), .held(held),
    .por_ok(por_ok), .warm_ok(warm_ok),
    .cfg_tmr_done(cfg_tmr_done), .opr_tmr_done(opr_tmr_done),
    .flash_busy(flash_busy), .phase(phase),
    .cfg_run(cfg_run), .opr_run(opr_run),
    .cfg_load(cfg_load), .cfg_done(cfg_done), .flash_abort(flash_abort)
  );

  assign access_rdy = (phase == PH_READY);
  // Lockout acts without a clock so a write cannot slip through a sync delay.
  assign wr_inhibit = ~access_rdy | lockout;
  // Logic outputs become valid once configuration is in, and stay valid on warm reset.
  assign pld_valid  = cfg_done;

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker (
  input logic clk,
  input logic supply_good,
  input logic lockout,
  input logic flash_busy,
  input logic cfg_load,
  input logic cfg_done,
  input logic pld_valid,
  input logic access_rdy,
  input logic wr_inhibit,
  input logic flash_abort
);

  assert_cfg_strobe_single_R3: assert property (@(posedge clk) disable iff (!supply_good)
    cfg_load |=> !cfg_load);

  assert_cfg_done_sticky_R3: assert property (@(posedge clk) disable iff (!supply_good)
    cfg_done |=> cfg_done);

  assert_pld_not_before_load_R4: assert property (@(posedge clk) disable iff (!supply_good)
    cfg_load |-> !pld_valid);

  assert_ready_needs_cfg_R5: assert property (@(posedge clk) disable iff (!supply_good)
    access_rdy |-> cfg_done);

  assert_abort_single_R7: assert property (@(posedge clk) disable iff (!supply_good)
    flash_abort |=> !flash_abort);

  assert_abort_needs_busy_R7: assert property (@(posedge clk) disable iff (!supply_good)
    flash_abort |-> $past(flash_busy));

  assert_abort_closes_access_R6: assert property (@(posedge clk) disable iff (!supply_good)
    flash_abort |-> !access_rdy);

  assert_ready_rise_idle_R8: assert property (@(posedge clk) disable iff (!supply_good)
    $rose(access_rdy) |-> $past(!flash_busy));

  assert_inhibit_cover_R9: assert property (@(posedge clk) disable iff (!supply_good)
    (lockout || !access_rdy) |-> wr_inhibit);

  always @(negedge clk) begin
    if (!supply_good) begin
      assert_offline_R10: assert (!access_rdy && !cfg_done && !cfg_load && !flash_abort)
        else $error("R10 outputs not cleared while supply is down");
    end
  end

endmodule

bind pwr_rst_seq rsq_checker u_chk (
  .clk(clk), .supply_good(supply_good), .lockout(lockout), .flash_busy(flash_busy),
  .cfg_load(cfg_load), .cfg_done(cfg_done), .pld_valid(pld_valid),
  .access_rdy(access_rdy), .wr_inhibit(wr_inhibit), .flash_abort(flash_abort)
);

// File: tb/sim_pwr_rst_seq.sv
module sim_pwr_rst_seq;

  localparam int SYNC  = 2;
  localparam int PORW  = 16;
  localparam int WARMW = 4;
  localparam int CFGN  = 8;
  localparam int OPRN  = 12;
  localparam int MAXW  = (PORW > WARMW) ? PORW : WARMW;

  // model phase codes
  localparam int M_OFF = 0, M_POR = 1, M_CFG = 2, M_OPR = 3, M_RDY = 4, M_WARM = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic supply_good = 1'b1;
  logic rst_pin_n   = 1'b1;
  logic lockout     = 1'b0;
  logic flash_busy  = 1'b0;
  logic cfg_load, cfg_done, pld_valid, access_rdy, wr_inhibit, flash_abort;

  pwr_rst_seq #(
    .SYNC_STAGES(SYNC), .POR_MIN_CYC(PORW), .WARM_MIN_CYC(WARMW),
    .CFG_LOAD_CYC(CFGN), .OPR_DELAY_CYC(OPRN)
  ) u0 (
    .clk(clk), .supply_good(supply_good), .rst_pin_n(rst_pin_n),
    .lockout(lockout), .flash_busy(flash_busy),
    .cfg_load(cfg_load), .cfg_done(cfg_done), .pld_valid(pld_valid),
    .access_rdy(access_rdy), .wr_inhibit(wr_inhibit), .flash_abort(flash_abort)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int abort_seen = 0;
  int cfgld_seen = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_st = M_OFF;
  int m_pw = 0;
  int m_rem = 0;
  bit m_done = 0, m_ld = 0, m_abt = 0;
  int m_hist[$];

  always @(posedge clk or negedge supply_good) begin
    if (!supply_good) begin
      m_st = M_OFF; m_pw = 0; m_rem = 0;
      m_done = 0; m_ld = 0; m_abt = 0;
      m_hist = {};
      for (int i = 0; i < SYNC; i++) m_hist.push_back(1);
    end else begin
      bit held, qp, qw;
      held = (m_hist[SYNC-1] == 0);
      m_hist.push_front(int'(rst_pin_n));
      void'(m_hist.pop_back());
      qp = held && (m_pw >= PORW - 1);
      qw = held && (m_pw >= WARMW - 1);
      m_pw = held ? ((m_pw < MAXW) ? m_pw + 1 : m_pw) : 0;
      m_ld = 0;
      m_abt = 0;
      case (m_st)
        M_OFF, M_POR: begin
          if (qp) begin m_st = M_CFG; m_rem = CFGN; m_ld = 1; end
          else if (held) m_st = M_POR;
          else m_st = M_OFF;
        end
        M_CFG: begin
          m_rem--;
          if (m_rem == 0) begin
            m_done = 1;
            m_st = held ? M_WARM : M_OPR;
            m_rem = OPRN;
          end
        end
        M_WARM: if (!held) begin m_st = M_OPR; m_rem = OPRN; end
        M_OPR: begin
          if (qw) begin m_st = M_WARM; m_abt = flash_busy; end
          else begin
            if (m_rem > 0) m_rem--;
            if (m_rem == 0 && !flash_busy) m_st = M_RDY;
          end
        end
        M_RDY: if (qw) begin m_st = M_WARM; m_abt = flash_busy; end
        default: m_st = M_OFF;
      endcase
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished && $time > 8) begin
      chk("R5", "access_rdy vs model", int'(access_rdy), int'(m_st == M_RDY));
      chk("R3", "cfg_load vs model", int'(cfg_load), int'(m_ld));
      chk("R3", "cfg_done vs model", int'(cfg_done), int'(m_done));
      chk("R4", "pld_valid vs model", int'(pld_valid), int'(m_done));
      chk("R7", "flash_abort vs model", int'(flash_abort), int'(m_abt));
      chk("R9", "wr_inhibit vs model", int'(wr_inhibit), int'((m_st != M_RDY) || lockout));
      if (flash_abort) abort_seen++;
      if (cfg_load) cfgld_seen++;
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1 supply_good = 1'b0;
    step(3);
    chk("R10", "access_rdy supply down", int'(access_rdy), 0);
    chk("R10", "cfg_done supply down", int'(cfg_done), 0);
    supply_good = 1'b1;
    step(4);
    chk("R1", "access_rdy idle", int'(access_rdy), 0);
    chk("R1", "wr_inhibit idle", int'(wr_inhibit), 1);
    chk("R1", "pld_valid idle", int'(pld_valid), 0);

    // too-short power-on pulse
    rst_pin_n = 1'b0; step(PORW - 2);
    rst_pin_n = 1'b1; step(10);
    chk("R2", "cfg_load count after short pulse", cfgld_seen, 0);
    chk("R2", "cfg_done after short pulse", int'(cfg_done), 0);

    // full power-on reset held past configuration
    rst_pin_n = 1'b0; step(SYNC + PORW + CFGN + 4);
    chk("R3", "cfg_load count", cfgld_seen, 1);
    chk("R3", "cfg_done after load", int'(cfg_done), 1);
    chk("R4", "pld_valid after load", int'(pld_valid), 1);
    chk("R5", "access_rdy while held", int'(access_rdy), 0);
    rst_pin_n = 1'b1; step(SYNC + OPRN);
    chk("R5", "access_rdy one edge early", int'(access_rdy), 0);
    step(1);
    chk("R5", "access_rdy at hold-off end", int'(access_rdy), 1);

    // warm glitch
    rst_pin_n = 1'b0; step(WARMW - 2);
    rst_pin_n = 1'b1; step(8);
    chk("R6", "access_rdy after glitch", int'(access_rdy), 1);
    chk("R6", "no reload after glitch", cfgld_seen, 1);

    // warm reset, memory idle
    rst_pin_n = 1'b0; step(SYNC + WARMW - 1);
    chk("R6", "access_rdy before warm qualifies", int'(access_rdy), 1);
    step(1);
    chk("R6", "access_rdy after warm qualifies", int'(access_rdy), 0);
    chk("R4", "pld_valid during warm reset", int'(pld_valid), 1);
    step(2);
    chk("R7", "no abort when idle", abort_seen, 0);
    rst_pin_n = 1'b1; step(SYNC + OPRN + 1);
    chk("R5", "access_rdy after warm hold-off", int'(access_rdy), 1);

    // warm reset during erase
    flash_busy = 1'b1;
    rst_pin_n = 1'b0; step(SYNC + WARMW + 1);
    chk("R7", "abort during erase", abort_seen, 1);
    step(4);
    chk("R7", "abort single pulse", abort_seen, 1);
    rst_pin_n = 1'b1; step(40);
    chk("R8", "access_rdy while busy", int'(access_rdy), 0);
    flash_busy = 1'b0; step(1);
    chk("R8", "access_rdy once idle", int'(access_rdy), 1);

    // supply lockout in ready
    lockout = 1'b1; step(1);
    chk("R9", "wr_inhibit under lockout", int'(wr_inhibit), 1);
    chk("R9", "access_rdy under lockout", int'(access_rdy), 1);
    lockout = 1'b0; step(1);
    chk("R9", "wr_inhibit lockout gone", int'(wr_inhibit), 0);

    // supply loss and restart with pin already low
    supply_good = 1'b0; step(1);
    chk("R10", "cfg_done after supply loss", int'(cfg_done), 0);
    chk("R10", "access_rdy after supply loss", int'(access_rdy), 0);
    rst_pin_n = 1'b0;
    supply_good = 1'b1; step(3);
    chk("R4", "pld_valid after restart", int'(pld_valid), 0);
    step(40);
    rst_pin_n = 1'b1; step(SYNC + OPRN + 2);
    chk("R5", "access_rdy after second power-on", int'(access_rdy), 1);
    chk("R3", "second cfg_load", cfgld_seen, 2);

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R5 watchdog actual=running expected=done");
      finish_run();
    end
  end

endmodule